// File: doc/BRIEF.md
# In-Place Reversible Squarer for GF(2^10)

This block squares an element of the binary field GF(2^10) built on the trinomial x^10 + x^3 + 1. The whole computation happens inside one 10-bit working register with no scratch storage. Each step XORs one register bit into another. The steps are grouped into layers, and no two steps in a layer touch the same bit, so a layer can update in a single clock. Running the same layers in the opposite order undoes the square, so the block can also take a square root.

A caller pulses `start_i` with an operand on `load_i` and a mode on `rev_i`. In forward mode (`rev_i`=0) the operand is A and the result is A^2 mod f(x). In reverse mode (`rev_i`=1) the operand is a square B and the result is the unique A with A^2 = B. The working register keeps the forward result in a scrambled bit order. A fixed bit permutation sits on the load path and on the output path, so both operand and result are in normal order at the ports. The controller has three states. `ST_IDLE` waits for a start and moves to `ST_RUN` when one is accepted. `ST_RUN` applies one layer per clock and moves to `ST_DONE` after the last layer. `ST_DONE` raises `done_o` for one cycle and always returns to `ST_IDLE`.

Top module: `gf_sq_inplace`

## Requirements
- R1: After reset, `value_o` is 0 and `done_o` is 0.
- R2: In forward mode, the result on `value_o` equals the operand squared modulo x^10 + x^3 + 1. Bit k of `load_i` and of `value_o` is the coefficient of x^k.
- R3: In reverse mode, loading B = A^2 mod f(x) gives A on `value_o`. Bit k is the coefficient of x^k.
- R4: `start_i` is sampled at clock edge k in `ST_IDLE`. `done_o` is then high only in the cycle that follows edge k+2, and low in the cycles before and after it.
- R5: While an operation is in progress, up to and including its `done_o` cycle, `start_i`, `load_i` and `rev_i` have no effect on the result or on when it finishes. The mode and the operand are captured when the start is accepted.
- R6: Once `done_o` has been high, `value_o` keeps the result until the next start is accepted, whatever `load_i` and `rev_i` do.
- R7: Squaring a value in forward mode and then feeding the result back in reverse mode returns the original value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation; accepted only in `ST_IDLE` |
| rev_i | input | 1 | Mode: 0 = square, 1 = square root |
| load_i | input | 10 | Operand, bit k is the coefficient of x^k |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| value_o | output | 10 | Working register shown in normal bit order |

## Verification
Every one of the 1024 field elements is squared and compared with a shift-and-reduce reference. A layer wired to the wrong bit, or a wrong output permutation, shows up as a mismatch for some element. Every square is also fed back in reverse mode. A wrong layer order, or a missing scatter on load, would fail to give back the original value. Extra starts with a flipped mode and a different operand are driven in every busy cycle and in the done cycle. A controller that re-arms early would move `done_o` or overwrite the result. The `done_o` timing and the value held while idle are checked cycle by cycle to catch any off-by-one in the layer counter.

// File: rtl/gfsq_pkg.sv
package gfsq_pkg;

    // Field width and number of conflict-free XOR layers
    localparam int FW     = 10;
    localparam int NLAYER = 2;
    localparam int STEP_W = (NLAYER > 1) ? $clog2(NLAYER) : 1;
    localparam int HALF   = FW / 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sq_state_e;

    // Source bit XORed into target bit tgt during a layer, or -1 for none.
    // Layer 0: each upper coefficient a(h+5) folds into bit h (h = 0..4).
    // Layer 1: a9 also folds into bit 2; it conflicts with a7 -> bit 2.
    function automatic int layer_src(input int layer, input int tgt);
        int src;
        src = -1;
        if (layer == 0) begin
            if (tgt < HALF) src = tgt + HALF;
        end else if (layer == 1) begin
            if (tgt == 2) src = FW - 1;
        end
        return src;
    endfunction

    // Register bit that holds output coefficient k after forward squaring
    function automatic int home_pos(input int k);
        int pos;
        if ((k % 2) == 0)
            pos = k / 2;
        else if (k == 1)
            pos = FW - 1;
        else
            pos = (k + 7) / 2;
        return pos;
    endfunction

endpackage

// File: rtl/gfsq_xor_layer.sv
module gfsq_xor_layer
    import gfsq_pkg::*;
#(
    parameter int LAYER = 0
) (
    input  logic [FW-1:0] d_i,
    output logic [FW-1:0] q_o
);

    for (genvar t = 0; t < FW; t++) begin : g_bit
        localparam int SRC = layer_src(LAYER, t);
        if (SRC >= 0) begin : g_xor
            assign q_o[t] = d_i[t] ^ d_i[SRC];
        end else begin : g_pass
            assign q_o[t] = d_i[t];
        end
    end

endmodule

// File: rtl/gfsq_step_unit.sv
module gfsq_step_unit
    import gfsq_pkg::*;
(
    input  logic [FW-1:0]     d_i,
    input  logic [STEP_W-1:0] layer_i,
    output logic [FW-1:0]     q_o
);

    logic [FW-1:0] lay_out [NLAYER];

    for (genvar l = 0; l < NLAYER; l++) begin : g_layer
        gfsq_xor_layer #(.LAYER(l)) u_layer (
            .d_i (d_i),
            .q_o (lay_out[l])
        );
    end

    assign q_o = lay_out[layer_i];

endmodule

// File: rtl/gfsq_perm.sv
module gfsq_perm
    import gfsq_pkg::*;
#(
    parameter bit SCATTER = 1'b0
) (
    input  logic [FW-1:0] d_i,
    output logic [FW-1:0] q_o
);

    for (genvar k = 0; k < FW; k++) begin : g_map
        localparam int POS = home_pos(k);
        if (SCATTER) begin : g_sc
            assign q_o[POS] = d_i[k];
        end else begin : g_ga
            assign q_o[k] = d_i[POS];
        end
    end

endmodule

// File: rtl/gfsq_ctrl.sv
module gfsq_ctrl
    import gfsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rev_i,
    output logic              load_en_o,
    output logic              step_en_o,
    output logic [STEP_W-1:0] layer_o,
    output logic              rev_o,
    output logic              done_o,
    output sq_state_e         state_o
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(NLAYER - 1);

    sq_state_e         state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic              rev_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (step_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, layer counter and captured mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            rev_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                step_q <= '0;
                rev_q  <= rev_i;
            end else if (state_q == ST_RUN && step_q != LAST) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        load_en_o = 1'b0;
        step_en_o = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: load_en_o = start_i;
            ST_RUN:  step_en_o = 1'b1;
            ST_DONE: done_o    = 1'b1;
            default: ;
        endcase
    end

    assign layer_o = rev_q ? (LAST - step_q) : step_q;
    assign rev_o   = rev_q;
    assign state_o = state_q;

endmodule

// File: rtl/gf_sq_inplace.sv
module gf_sq_inplace
    import gfsq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          rev_i,
    input  logic [FW-1:0] load_i,
    output logic          done_o,
    output logic [FW-1:0] value_o
);

    logic              load_en;
    logic              step_en;
    logic [STEP_W-1:0] layer_sel;
    logic              rev_mode;
    sq_state_e         fsm_state;
    logic [FW-1:0]     acc_q;
    logic [FW-1:0]     acc_step;
    logic [FW-1:0]     load_scat;
    logic [FW-1:0]     acc_gath;

    gfsq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rev_i     (rev_i),
        .load_en_o (load_en),
        .step_en_o (step_en),
        .layer_o   (layer_sel),
        .rev_o     (rev_mode),
        .done_o    (done_o),
        .state_o   (fsm_state)
    );

    gfsq_step_unit u_step (
        .d_i     (acc_q),
        .layer_i (layer_sel),
        .q_o     (acc_step)
    );

    // Reverse operands enter in the register's scrambled layout
    gfsq_perm #(.SCATTER(1'b1)) u_scatter (
        .d_i (load_i),
        .q_o (load_scat)
    );

    // Forward results leave in normal coefficient order
    gfsq_perm #(.SCATTER(1'b0)) u_gather (
        .d_i (acc_q),
        .q_o (acc_gath)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_en) begin
            acc_q <= rev_i ? load_scat : load_i;
        end else if (step_en) begin
            acc_q <= acc_step;
        end
    end

    assign value_o = rev_mode ? acc_q : acc_gath;

endmodule

// File: rtl/gfsq_sva.sv
module gfsq_sva
    import gfsq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          done_o,
    input  logic [FW-1:0] value_o,
    input  logic [FW-1:0] acc_q,
    input  sq_state_e     fsm_state
);

    // R4: done lasts exactly one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: done follows an accepted start by three edges
    p_done_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 3));

    // R2: source coefficients (upper half) are never written while running
    p_src_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RUN) |=> $stable(acc_q[FW-1:HALF]));

    // R5: a start in the done cycle does not re-arm the block
    p_done_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DONE) |=> (fsm_state == ST_IDLE));

    // R6: the result holds while idle without a start
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && !start_i) |=> $stable(value_o));

endmodule

bind gf_sq_inplace gfsq_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .done_o    (done_o),
    .value_o   (value_o),
    .acc_q     (acc_q),
    .fsm_state (fsm_state)
);

// File: tb/tb_gf_sq_inplace.sv
module tb_gf_sq_inplace;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rev_i = 1'b0;
    logic [9:0] load_i = '0;
    logic       done_o;
    logic [9:0] value_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [9:0] exp_q [$];
    string      tag_q [$];
    logic [9:0] last_val;

    always #2 clk = ~clk;   // 250 MHz

    gf_sq_inplace dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .rev_i   (rev_i),
        .load_i  (load_i),
        .done_o  (done_o),
        .value_o (value_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference: shift-and-add product, then reduce by x^10 + x^3 + 1
    function automatic logic [9:0] ref_sq(input logic [9:0] a);
        logic [18:0] p;
        p = '0;
        for (int i = 0; i < 10; i++)
            if (a[i]) p = p ^ (19'(a) << i);
        for (int d = 18; d >= 10; d--)
            if (p[d]) p = p ^ (19'h409 << (d - 10));
        return p[9:0];
    endfunction

    // Monitor: pop one expected item each time done is seen
    always @(negedge clk) begin
        if (rst_n && done_o && !finished) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4_unexpected_done", value_o, '0);
            end else begin
                automatic logic [9:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(value_o === e, t, value_o, e);
            end
        end
    end

    // Driver: one operation; poke drives stray starts while busy
    task automatic run_op(input logic [9:0] val, input logic rev, input logic [9:0] exp,
                          input string tag, input bit poke);
        @(negedge clk);
        start_i = 1'b1; load_i = val; rev_i = rev;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        chk(done_o == 1'b0, "R4_early1", {9'b0, done_o}, 10'd0);
        if (poke) begin start_i = 1'b1; load_i = ~val; rev_i = ~rev; end
        else start_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R4_early2", {9'b0, done_o}, 10'd0);
        @(negedge clk);
        chk(done_o == 1'b1, "R4_done", {9'b0, done_o}, 10'd1);
        if (poke) begin start_i = 1'b1; load_i = val ^ 10'h155; rev_i = ~rev; end
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R4_single", {9'b0, done_o}, 10'd0);
        if (poke) chk(value_o === exp, "R5_busy_start", value_o, exp);
        last_val = value_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(value_o === 10'd0, "R1_value", value_o, 10'd0);
        chk(done_o === 1'b0, "R1_done", {9'b0, done_o}, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(value_o === 10'd0, "R1_after_release", value_o, 10'd0);

        // R2: every element squared
        for (int a = 0; a < 1024; a++)
            run_op(10'(a), 1'b0, ref_sq(10'(a)), "R2_square", (a % 64) == 7);

        // R3: every square rooted
        for (int a = 0; a < 1024; a++)
            run_op(ref_sq(10'(a)), 1'b1, 10'(a), "R3_root", (a % 64) == 11);

        // R7: round trip through the port values
        for (int j = 0; j < 16; j++) begin
            automatic logic [9:0] v = 10'((j * 67 + 13) % 1024);
            run_op(v, 1'b0, ref_sq(v), "R7_fwd", 1'b0);
            run_op(last_val, 1'b1, v, "R7_roundtrip", 1'b0);
        end

        // R6: result holds while idle despite input changes
        run_op(10'h2A5, 1'b0, ref_sq(10'h2A5), "R6_setup", 1'b0);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            load_i = 10'(j * 91); rev_i = j[0];
            chk(value_o === ref_sq(10'h2A5), "R6_hold", value_o, ref_sq(10'h2A5));
            chk(done_o === 1'b0, "R6_no_done", {9'b0, done_o}, 10'd0);
        end

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R4_all_done_seen", 10'(exp_q.size()), 10'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule